// File: doc/BRIEF.md
# Sectored Translation Lookaside Buffer

This block is a fully associative address translation cache in which one associative tag stands for a whole group of neighbouring page table entries. That group is exactly what a single cache line read returns to the page walker. A lookup compares the upper bits of the virtual page number against every stored tag. The low bits of the page number then pick one slot inside the matching group. One cycle later the block reports either the physical page number with a hit, or a miss.

Every slot has its own presence flag. When a walker fills a group, it hands over all of its entries at once, and that includes neighbours that are not present. A group counts as a hit only where the tag matches and the addressed slot is marked present.

A second port writes complete groups. A third port removes either one group, selected by address, or every group at once. The page walker and the data cache sit outside this block.

Top module: `sector_tlb`

## Requirements
- R1: After reset no group is held. The first lookup misses, and `lk_hit`, `lk_miss` and `lk_ppn` are all zero until a lookup completes.
- R2: A lookup presented in cycle n reports in cycle n+1. Exactly one of `lk_hit` and `lk_miss` is high when `lk_req` was high in cycle n, and both are low otherwise. `lk_ppn` is zero unless `lk_hit` is high.
- R3: A group's tag is the virtual page number without its low log2(GROUP) bits, and those low bits select the slot. In a fill, slot s takes bits [s*PPN_W +: PPN_W] of `fl_ppn` and presence bit s of `fl_vld`.
- R4: A hit needs two things: a held group whose tag matches, and a present addressed slot. When the tag matches but the slot is not present, the lookup reports a miss and `lk_ppn` stays zero.
- R5: A fill whose presence vector is nonzero stores the whole group, including the absent slots and their presence bits.
- R6: A fill whose presence vector is all zero changes nothing. It allocates no group, and it leaves any held group with the same tag unchanged.
- R7: A fill whose tag equals a held group's tag overwrites that group in place. No two held groups ever share a tag.
- R8: A fill with a new tag takes the lowest-numbered empty entry. When every entry is held, it evicts the entry named by a rotating pointer. That pointer starts at 0 after reset and advances by one, wrapping, after each eviction.
- R9: A single invalidate empties every slot of the group whose tag matches `inv_vpn`. When no group matches, it has no effect.
- R10: A full invalidate empties every entry.
- R11: An invalidate of either kind in the same cycle as a fill drops the fill. A lookup in the same cycle as a fill or an invalidate sees the contents from before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Registered: translation found |
| lk_miss | output | 1 | Registered: no present translation |
| lk_ppn | output | PPN_W | Registered physical page number, zero on a miss |
| fl_req | input | 1 | Group fill request |
| fl_vpn | input | VPN_W | Any page number inside the group being filled |
| fl_ppn | input | GROUP*PPN_W | Physical page numbers of all slots, slot 0 lowest |
| fl_vld | input | GROUP | Presence bit per slot |
| inv_all | input | 1 | Empty every entry |
| inv_one | input | 1 | Empty the group matching inv_vpn |
| inv_vpn | input | VPN_W | Page number whose group is invalidated |

## Verification
The bench builds the block with its defaults: groups of four, sixteen entries, 20-bit page numbers. With groups of four, every presence pattern from one present slot to all four can be driven, so lookups can land on absent neighbours. The first directed phase fills more than sixteen distinct tags, which drives the rotating pointer through several evictions. A random phase then mixes same-cycle fills, invalidates and lookups over twenty-four tags, so tags collide often and in-place overwrites happen repeatedly.

// File: rtl/sectlb_pkg.sv
// Shared types for the sectored TLB.
// Assumes nothing beyond the importing modules' parameters.
package sectlb_pkg;

    // How a fill lands in the entry array in a given cycle.
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_INPLACE = 2'd1,
        WR_FREE    = 2'd2,
        WR_EVICT   = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/sectlb_match.sv
// Associative compare of one key against every held tag.
// Assumes at most one held entry matches any key; the index output
// is the OR of matching indices and is valid only when any_o is set.
module sectlb_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 18,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [ENTRIES-1:0]            held_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic [ENTRIES-1:0]            vec_o,
    output logic                          any_o,
    output logic [IDX_W-1:0]              idx_o
);

    // Per-entry equality gated by the entry being held.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            vec_o[e] = held_i[e] && (tags_i[e] == key_i);
        end
    end

    // Encode the matching position.
    always_comb begin
        idx_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vec_o[e]) idx_o = idx_o | IDX_W'(e);
        end
        any_o = |vec_o;
    end

endmodule

// File: rtl/sectlb_victim.sv
// Chooses where a fill with a new tag goes: lowest empty entry, or the
// rotating pointer when the array is full. Assumes ENTRIES is a power
// of two so the pointer wraps naturally.
module sectlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] held_i,
    input  logic               take_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               full_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;

    // Lowest-numbered empty entry.
    always_comb begin
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!held_i[e]) free_idx = IDX_W'(e);
        end
        full_o = &held_i;
        idx_o  = full_o ? ptr_q : free_idx;
    end

    // Rotating eviction pointer, stepped only by an eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take_i && full_o) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    AST_VICTIM_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> held_i[$past(idx_o)]); // R8

endmodule

// File: rtl/sector_tlb.sv
// Sectored TLB: each tag covers GROUP adjacent page table entries with a
// presence bit per slot. Lookup result is registered (one cycle).
// Assumes GROUP is 2 or 4 and ENTRIES a power of two. Invalidates take
// precedence over a same-cycle fill; lookups read pre-edge contents.
module sector_tlb
    import sectlb_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 16,
    parameter int GROUP   = 4,
    localparam int SLOT_W = $clog2(GROUP),
    localparam int TAG_W  = VPN_W - SLOT_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_req,
    input  logic [VPN_W-1:0]       lk_vpn,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PPN_W-1:0]       lk_ppn,
    input  logic                   fl_req,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [GROUP*PPN_W-1:0] fl_ppn,
    input  logic [GROUP-1:0]       fl_vld,
    input  logic                   inv_all,
    input  logic                   inv_one,
    input  logic [VPN_W-1:0]       inv_vpn
);

    logic [ENTRIES-1:0][TAG_W-1:0]            tag_q;
    logic [ENTRIES-1:0][GROUP-1:0][PPN_W-1:0] ppn_q;
    logic [ENTRIES-1:0][GROUP-1:0]            sv_q;
    logic [ENTRIES-1:0]                       held;

    // An entry is held while any of its slots is present.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_held
        assign held[e] = |sv_q[e];
    end

    // Three searches share one compare structure.
    localparam int NSRCH = 3;
    logic [NSRCH-1:0][TAG_W-1:0]   keys;
    logic [NSRCH-1:0][ENTRIES-1:0] mvec;
    logic [NSRCH-1:0]              many;
    logic [NSRCH-1:0][IDX_W-1:0]   midx;

    assign keys[0] = lk_vpn[VPN_W-1:SLOT_W];
    assign keys[1] = fl_vpn[VPN_W-1:SLOT_W];
    assign keys[2] = inv_vpn[VPN_W-1:SLOT_W];

    for (genvar s = 0; s < NSRCH; s++) begin : g_srch
        sectlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
            .tags_i (tag_q),
            .held_i (held),
            .key_i  (keys[s]),
            .vec_o  (mvec[s]),
            .any_o  (many[s]),
            .idx_o  (midx[s])
        );
    end

    // Lookup decision on pre-edge contents.
    logic [SLOT_W-1:0] lk_slot;
    logic              hit_c;
    assign lk_slot = lk_vpn[SLOT_W-1:0];
    assign hit_c   = many[0] && sv_q[midx[0]][lk_slot];

    // Register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_miss <= 1'b0;
            lk_ppn  <= '0;
        end else begin
            lk_hit  <= lk_req && hit_c;
            lk_miss <= lk_req && !hit_c;
            lk_ppn  <= (lk_req && hit_c) ? ppn_q[midx[0]][lk_slot] : '0;
        end
    end

    // Fill placement.
    logic             do_fill;
    logic             vic_full;
    logic [IDX_W-1:0] vic_idx;
    logic [IDX_W-1:0] w_idx;
    wr_kind_e         wr_kind;

    assign do_fill = fl_req && (fl_vld != '0) && !inv_all && !inv_one;

    sectlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .held_i (held),
        .take_i (do_fill && !many[1]),
        .idx_o  (vic_idx),
        .full_o (vic_full)
    );

    // Classify the fill and pick its target entry.
    always_comb begin
        if (!do_fill)     wr_kind = WR_NONE;
        else if (many[1]) wr_kind = WR_INPLACE;
        else if (vic_full) wr_kind = WR_EVICT;
        else              wr_kind = WR_FREE;
        w_idx = (wr_kind == WR_INPLACE) ? midx[1] : vic_idx;
    end

    // Presence bits: invalidates first, then fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
        end else if (inv_all) begin
            sv_q <= '0;
        end else if (inv_one) begin
            if (many[2]) sv_q[midx[2]] <= '0;
        end else if (wr_kind != WR_NONE) begin
            sv_q[w_idx] <= fl_vld;
        end
    end

    // Tag and translation payload; data carries no reset.
    always_ff @(posedge clk) begin
        if (wr_kind != WR_NONE) begin
            tag_q[w_idx] <= keys[1];
            ppn_q[w_idx] <= fl_ppn;
        end
    end

    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss)); // R2

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mvec[0]) && $onehot0(mvec[1])); // R7

    AST_EMPTY_FILL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_vld == '0 && !inv_all && !inv_one) |=> $stable(sv_q)); // R6

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (held == '0)); // R10

    AST_INV_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one && !inv_all && !many[2]) |=> $stable(sv_q)); // R11

endmodule

// File: tb/tb_sector_tlb.sv
// Cycle-by-cycle behavioural model of the sectored TLB, compared every cycle.
module tb_sector_tlb;

    localparam int VW = 20;
    localparam int PW = 20;
    localparam int N  = 16;
    localparam int G  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic lk_hit, lk_miss;
    logic [PW-1:0] lk_ppn;
    logic fl_req = 0;
    logic [VW-1:0] fl_vpn = '0;
    logic [G*PW-1:0] fl_ppn = '0;
    logic [G-1:0] fl_vld = '0;
    logic inv_all = 0, inv_one = 0;
    logic [VW-1:0] inv_vpn = '0;

    always #2 clk = ~clk;

    sector_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
        .fl_req(fl_req), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_vld(fl_vld),
        .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn)
    );

    // Model state
    int  m_tag [N];
    int  m_ppn [N][G];
    bit  m_sv  [N][G];
    int  m_ptr;
    int  n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit  e_hit, e_miss;
    int  e_ppn;

    function automatic bit m_held(int e);
        for (int s = 0; s < G; s++) if (m_sv[e][s]) return 1;
        return 0;
    endfunction

    function automatic int m_find(int tag);
        for (int e = 0; e < N; e++) if (m_held(e) && m_tag[e] == tag) return e;
        return -1;
    endfunction

    // Compute this cycle's expectation, then apply this cycle's updates.
    task automatic model_step();
        int e;
        int lt, ls;
        lt = int'(lk_vpn) / G; ls = int'(lk_vpn) % G;
        e = m_find(lt);
        e_hit  = lk_req && e >= 0 && m_sv[e][ls];
        e_miss = lk_req && !e_hit;
        e_ppn  = e_hit ? m_ppn[e][ls] : 0;
        if (inv_all) begin
            for (int i = 0; i < N; i++) for (int s = 0; s < G; s++) m_sv[i][s] = 0;
        end else if (inv_one) begin
            e = m_find(int'(inv_vpn) / G);
            if (e >= 0) for (int s = 0; s < G; s++) m_sv[e][s] = 0;
        end else if (fl_req && fl_vld != 0) begin
            e = m_find(int'(fl_vpn) / G);
            if (e < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_held(i)) e = i;
                if (e < 0) begin e = m_ptr; m_ptr = (m_ptr + 1) % N; end
            end
            m_tag[e] = int'(fl_vpn) / G;
            for (int s = 0; s < G; s++) begin
                m_sv[e][s]  = fl_vld[s];
                m_ppn[e][s] = int'(fl_ppn[s*PW +: PW]);
            end
        end
    endtask

    task automatic idle();
        lk_req = 0; fl_req = 0; inv_all = 0; inv_one = 0; fl_vld = '0;
    endtask

    task automatic compare();
        n_vec++;
        if (lk_hit !== e_hit || lk_miss !== e_miss || int'(lk_ppn) != e_ppn) begin
            n_bad++;
            $display("FAIL %s: hit=%0b miss=%0b ppn=%0h expected hit=%0b miss=%0b ppn=%0h",
                     cur_req, lk_hit, lk_miss, lk_ppn, e_hit, e_miss, e_ppn);
        end
    endtask

    // One cycle: inputs already set after a negedge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic look(int vpn);
        lk_req = 1; lk_vpn = VW'(vpn); tick();
    endtask

    task automatic fill(int vpn, logic [G-1:0] v, int base);
        fl_req = 1; fl_vpn = VW'(vpn); fl_vld = v;
        for (int s = 0; s < G; s++) fl_ppn[s*PW +: PW] = PW'(base + s);
        tick();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0;
            for (int s = 0; s < G; s++) begin m_sv[i][s] = 0; m_ppn[i][s] = 0; end
        end
        m_ptr = 0; e_hit = 0; e_miss = 0; e_ppn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: outputs idle after reset, first lookup misses
        cur_req = "R1"; tick();
        look('h100);
        // R3 R5: partial group, slot data positions
        cur_req = "R5"; fill('h40, 4'b0101, 'h500);
        cur_req = "R3"; look('h40); look('h42);
        cur_req = "R4"; look('h41); look('h43); look('h44);
        // R2: no request gives idle outputs
        cur_req = "R2"; tick();
        // R6: empty fill on new and existing tags
        cur_req = "R6"; fill('h80, 4'b0000, 'h900); look('h80);
        fill('h41, 4'b0000, 'h900); look('h40); look('h42);
        // R7: in-place overwrite
        cur_req = "R7"; fill('h43, 4'b1010, 'h700);
        look('h40); look('h41); look('h43);
        // R8: fill beyond capacity, evictions rotate
        cur_req = "R8";
        for (int t = 0; t < 22; t++) fill('h1000 + t*G, 4'b1111, 'h2000 + t*16);
        for (int t = 0; t < 22; t++) look('h1000 + t*G + (t % G));
        look('h41);
        // R9: single invalidate, matching and not
        cur_req = "R9";
        inv_one = 1; inv_vpn = VW'('h1000 + 21*G + 3); tick();
        look('h1000 + 21*G); look('h1000 + 20*G + 1);
        inv_one = 1; inv_vpn = VW'('hFFF0); tick(); look('h1000 + 20*G + 2);
        // R11: invalidate drops a same-cycle fill; lookup sees pre-edge state
        cur_req = "R11";
        inv_one = 1; inv_vpn = VW'('h1000 + 19*G);
        fl_req = 1; fl_vpn = VW'('h3000); fl_vld = 4'b1111; lk_req = 1; lk_vpn = VW'('h1000 + 19*G);
        tick();
        look('h3000); look('h1000 + 19*G);
        fl_req = 1; fl_vpn = VW'('h3100); fl_vld = 4'b0001; fl_ppn = '0;
        lk_req = 1; lk_vpn = VW'('h3100); tick(); look('h3100);
        // R10: flush everything
        cur_req = "R10"; inv_all = 1; fl_req = 1; fl_vpn = VW'('h3200); fl_vld = 4'b1111; tick();
        look('h3100); look('h3200); look('h1000 + 18*G);
        // R2 R4: random mix over a small tag space
        cur_req = "R2/R4";
        for (int c = 0; c < 3000; c++) begin
            lk_req = ($urandom % 4) != 0;
            lk_vpn = VW'($urandom % (24 * G));
            if ($urandom % 10 < 3) begin
                fl_req = 1; fl_vpn = VW'($urandom % (24 * G));
                fl_vld = G'($urandom); fl_ppn = {$urandom, $urandom, $urandom};
            end
            inv_one = ($urandom % 32) == 0;
            inv_vpn = VW'($urandom % (24 * G));
            inv_all = ($urandom % 256) == 0;
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule